// File: doc/BRIEF.md
# NAND Flash Identification and Geometry Probe

This block performs the start-up identification of a NAND flash device through a narrow command, address and data port. When asked to start, it sends the device a reset command and waits for the ready input. It then issues the identification command with one zero address byte and reads back the manufacturer code and the device code.

The device code is looked up in a small built-in geometry table. Each table entry gives the page size, the chip capacity, the erase-block size and the bus width. Some entries leave the page size or the erase size open. For those devices the probe reads three more identification bytes and decodes both sizes from the last of them.

From the resolved geometry the block derives the number of address cycles the device needs and the number of erase blocks. It presents all results as registered outputs with a done flag. An unknown device or an unsupported page size raises an error flag instead. Sizes are reported as base-2 logarithms of their byte counts.

Top module: `nand_id_probe`

## Requirements
- R1: A `start` pulse while idle produces three single-cycle strobes on `cmd_stb`, in this order: byte 0xFF with `cmd_addr`=0, then byte 0x90 with `cmd_addr`=0, then byte 0x00 with `cmd_addr`=1. The 0x90 strobe follows only after `dev_ready` has been sampled high in a cycle after the 0xFF strobe, and the 0x00 strobe comes in the cycle right after the 0x90 strobe.
- R2: Each data read holds `rd_req` high until a cycle with `rd_valid` high, and only bits [7:0] of `rd_data` are used. The first read gives the manufacturer code and the second gives the device code.
- R3: An entry matches when its device code equals the read device code and its manufacturer field either equals the read manufacturer code or is 0x00. The entries, as device/manufacturer: page log2, chip MiB, erase log2, width, are: D7/EC: 13,4096,20,x8; EC/00: 8,1,12,x8; 73/00: 9,16,14,x8; 76/00: 9,64,14,x8; 56/00: 9,64,14,x16; F1/00: open,128,open,x8; DA/00: open,256,open,x8; C1/00: open,128,open,x16; 9B/00: 9,16384,14,x8; 9A/00: open,65536,open,x8.
- R4: When no entry matches, `err` rises, `done` stays 0 and no further read is requested.
- R5: A matching entry with a 256-byte page (page log2 8) sets `err` and leaves `done` at 0.
- R6: When an entry leaves the page size or the erase size open, exactly three further reads follow. From the third of them (the fifth identification byte), `pg_lg` = 10 + bits [1:0] and `er_lg` = 16 + bits [5:4]. Its other bits, and the two bytes before it, have no effect.
- R7: `addr_cycles` depends on page size and chip size. With `pg_lg` ≤ 9 it is 3 up to 32 MiB, 4 up to 8 GiB and 5 above. With a larger page it is 4 up to 128 MiB, 5 up to 32 GiB and 6 above.
- R8: `blk_count` equals the chip size in bytes divided by 2^`er_lg`.
- R9: After reset, every output is 0.
- R10: A `start` pulse during a probe has no effect on it. A `start` accepted while idle clears `done` and `err` at the next clock edge.
- R11: `bus_wide` is 1 exactly when the matched entry is x16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe when idle |
| dev_ready | input | 1 | Device ready level |
| rd_valid | input | 1 | Read data valid this cycle |
| rd_data | input | DATA_W | Read data word, low byte used |
| cmd_stb | output | 1 | Command or address byte valid |
| cmd_addr | output | 1 | 1: strobe is an address byte, 0: a command |
| cmd_byte | output | 8 | Command or address value |
| rd_req | output | 1 | Data read requested |
| pg_lg | output | 4 | log2 of page bytes |
| er_lg | output | 5 | log2 of erase-block bytes |
| bus_wide | output | 1 | 1 for a 16-bit device |
| addr_cycles | output | 3 | Row-plus-column address cycle count |
| blk_count | output | BLK_W | Number of erase blocks |
| done | output | 1 | Probe finished with a valid geometry |
| err | output | 1 | Probe failed |

## Verification
A second `start` pulse can arrive in the same cycle as the probe's own activity: during the ready wait, during the identification reads, or in the decode cycle. A `rd_valid` answer can also land in the first cycle `rd_req` is raised. The bench provokes both. It replays probes with an extra `start` placed at several cycle offsets and runs every probe with read latencies of zero, one and two cycles. It then judges the overlap by requiring the same strobe sequence, the same read count and the same geometry as the probe without the interfering pulse.

// File: rtl/nand_probe_pkg.sv
package nand_probe_pkg;

   typedef struct packed {
      logic [7:0] mfr;      // 0x00 acts as wildcard
      logic [7:0] dev;
      logic [3:0] pg_lg;    // 0: open, decode from extended ID
      logic [4:0] chip_lg;  // log2 of capacity in MiB
      logic [4:0] er_lg;    // 0: open, decode from extended ID
      logic       wide;
   } geo_ent_t;

   localparam int unsigned ENT_N = 10;

   localparam geo_ent_t ENT_TBL [ENT_N] = '{
      '{8'hEC, 8'hD7, 4'd13, 5'd12, 5'd20, 1'b0},
      '{8'h00, 8'hEC, 4'd8,  5'd0,  5'd12, 1'b0},
      '{8'h00, 8'h73, 4'd9,  5'd4,  5'd14, 1'b0},
      '{8'h00, 8'h76, 4'd9,  5'd6,  5'd14, 1'b0},
      '{8'h00, 8'h56, 4'd9,  5'd6,  5'd14, 1'b1},
      '{8'h00, 8'hF1, 4'd0,  5'd7,  5'd0,  1'b0},
      '{8'h00, 8'hDA, 4'd0,  5'd8,  5'd0,  1'b0},
      '{8'h00, 8'hC1, 4'd0,  5'd7,  5'd0,  1'b1},
      '{8'h00, 8'h9B, 4'd9,  5'd14, 5'd14, 1'b0},
      '{8'h00, 8'h9A, 4'd0,  5'd16, 5'd0,  1'b0}
   };

   localparam logic [3:0] PG_LG_TINY  = 4'd8;
   localparam logic [3:0] PG_LG_SMALL = 4'd9;
   localparam logic [6:0] MIB_LG      = 7'd20;

   typedef enum logic [3:0] {
      P_IDLE, P_RCMD, P_RWAIT, P_ICMD, P_IADR,
      P_RMFR, P_RDEV, P_MATCH, P_REXT, P_FIN
   } probe_st_t;

endpackage

// File: rtl/nand_probe_lut.sv
module nand_probe_lut
   import nand_probe_pkg::*;
#(
   parameter int unsigned N = ENT_N
) (
   input  logic [7:0] mfr,
   input  logic [7:0] dev,
   output logic       hit,
   output geo_ent_t   ent
);

   logic [N-1:0] hv;

   generate
      if (N < 1 || N > ENT_N) begin : g_bad_n
         $error("nand_probe_lut: N out of range");
      end
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign hv[g] = (ENT_TBL[g].dev == dev) &&
                        ((ENT_TBL[g].mfr == mfr) || (ENT_TBL[g].mfr == 8'h00));
      end
   endgenerate

   // lowest index wins
   always_comb begin
      hit = 1'b0;
      ent = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hv[i]) begin
            hit = 1'b1;
            ent = ENT_TBL[i];
         end
      end
   end

endmodule

// File: rtl/nand_probe_geom.sv
module nand_probe_geom
   import nand_probe_pkg::*;
#(
   parameter int BLK_W = 24
) (
   input  geo_ent_t         ent,
   input  logic [7:0]       xb,
   output logic [3:0]       pg_lg,
   output logic [4:0]       er_lg,
   output logic [2:0]       ac,
   output logic [BLK_W-1:0] blk
);

   logic [6:0] sh;
   logic       small_pg;
   wire        unused_geo = ^{xb[7:6], xb[3:2], ent.mfr, ent.dev, ent.wide};

   generate
      if (BLK_W < 21 || BLK_W > 64) begin : g_bad_w
         $error("nand_probe_geom: BLK_W must be 21..64");
      end
   endgenerate

   always_comb begin
      pg_lg = (ent.pg_lg == 4'd0) ? (4'd10 + {2'b00, xb[1:0]}) : ent.pg_lg;
      er_lg = (ent.er_lg == 5'd0) ? (5'd16 + {3'b000, xb[5:4]}) : ent.er_lg;
   end

   assign small_pg = (pg_lg <= PG_LG_SMALL);

   always_comb begin
      if (small_pg) begin
         if (ent.chip_lg <= 5'd5)       ac = 3'd3;
         else if (ent.chip_lg <= 5'd13) ac = 3'd4;
         else                           ac = 3'd5;
      end else begin
         if (ent.chip_lg <= 5'd7)       ac = 3'd4;
         else if (ent.chip_lg <= 5'd15) ac = 3'd5;
         else                           ac = 3'd6;
      end
   end

   assign sh  = {2'b00, ent.chip_lg} + MIB_LG - {2'b00, er_lg};
   assign blk = (32'(sh) < BLK_W) ? (BLK_W'(1) << sh) : '0;

endmodule

// File: rtl/nand_probe_seq.sv
module nand_probe_seq
   import nand_probe_pkg::*;
#(
   parameter int         DATA_W    = 8,
   parameter int         EXT_N     = 3,
   parameter logic [7:0] OP_RESET  = 8'hFF,
   parameter logic [7:0] OP_READID = 8'h90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dev_ready,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cmd_stb,
   output logic              cmd_addr,
   output logic [7:0]        cmd_byte,
   output logic              rd_req,
   output logic [7:0]        mfr_q,
   output logic [7:0]        dev_q,
   input  logic              lut_hit,
   input  geo_ent_t          lut_ent,
   output geo_ent_t          ent_q,
   output logic [7:0]        xb_q,
   output logic              fin,
   output logic              done,
   output logic              err
);

   localparam int         XW    = (EXT_N > 1) ? $clog2(EXT_N) : 1;
   localparam logic [XW-1:0] XLAST = XW'(EXT_N - 1);

   probe_st_t   st;
   logic [XW-1:0] xcnt;
   logic [7:0]  rd_lo;

   generate
      if (DATA_W != 8 && DATA_W != 16) begin : g_bad_dw
         $error("nand_probe_seq: DATA_W must be 8 or 16");
      end
      if (EXT_N < 1) begin : g_bad_ext
         $error("nand_probe_seq: EXT_N must be at least 1");
      end
      if (DATA_W > 8) begin : g_wide
         wire unused_hi = ^rd_data[DATA_W-1:8];
         assign rd_lo = rd_data[7:0];
      end else begin : g_narrow
         assign rd_lo = rd_data[7:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= P_IDLE;
         mfr_q <= '0;
         dev_q <= '0;
         xb_q  <= '0;
         ent_q <= '0;
         xcnt  <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         case (st)
            P_IDLE: if (start) begin
               done <= 1'b0;
               err  <= 1'b0;
               st   <= P_RCMD;
            end
            P_RCMD:  st <= P_RWAIT;
            P_RWAIT: if (dev_ready) st <= P_ICMD;
            P_ICMD:  st <= P_IADR;
            P_IADR:  st <= P_RMFR;
            P_RMFR: if (rd_valid) begin
               mfr_q <= rd_lo;
               st    <= P_RDEV;
            end
            P_RDEV: if (rd_valid) begin
               dev_q <= rd_lo;
               st    <= P_MATCH;
            end
            P_MATCH: begin
               if (!lut_hit || lut_ent.pg_lg == PG_LG_TINY) begin
                  err <= 1'b1;
                  st  <= P_IDLE;
               end else begin
                  ent_q <= lut_ent;
                  xb_q  <= '0;
                  xcnt  <= '0;
                  st    <= (lut_ent.pg_lg == 4'd0 || lut_ent.er_lg == 5'd0) ? P_REXT : P_FIN;
               end
            end
            P_REXT: if (rd_valid) begin
               if (xcnt == XLAST) begin
                  xb_q <= rd_lo;
                  st   <= P_FIN;
               end else begin
                  xcnt <= xcnt + 1'b1;
               end
            end
            P_FIN: begin
               done <= 1'b1;
               st   <= P_IDLE;
            end
            default: st <= P_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_stb  = (st == P_RCMD) || (st == P_ICMD) || (st == P_IADR);
      cmd_addr = (st == P_IADR);
      cmd_byte = (st == P_RCMD) ? OP_RESET : ((st == P_ICMD) ? OP_READID : 8'h00);
      rd_req   = (st == P_RMFR) || (st == P_RDEV) || (st == P_REXT);
      fin      = (st == P_FIN);
   end

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> rd_req);

   assert_no_cmd_during_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_stb && rd_req));

   assert_ready_before_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && !cmd_addr && cmd_byte == OP_READID) |-> $past(dev_ready));

   assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   assert_err_stops_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !rd_req);

endmodule

// File: rtl/nand_id_probe.sv
module nand_id_probe
   import nand_probe_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BLK_W  = 24,
   parameter int EXT_N  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dev_ready,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cmd_stb,
   output logic              cmd_addr,
   output logic [7:0]        cmd_byte,
   output logic              rd_req,
   output logic [3:0]        pg_lg,
   output logic [4:0]        er_lg,
   output logic              bus_wide,
   output logic [2:0]        addr_cycles,
   output logic [BLK_W-1:0]  blk_count,
   output logic              done,
   output logic              err
);

   logic [7:0]       mfr_q, dev_q, xb_q;
   logic             lut_hit, fin;
   geo_ent_t         lut_ent, ent_q;
   logic [3:0]       g_pg;
   logic [4:0]       g_er;
   logic [2:0]       g_ac;
   logic [BLK_W-1:0] g_blk;

   nand_probe_seq #(.DATA_W(DATA_W), .EXT_N(EXT_N)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_ready(dev_ready),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_byte(cmd_byte), .rd_req(rd_req),
      .mfr_q(mfr_q), .dev_q(dev_q), .lut_hit(lut_hit), .lut_ent(lut_ent),
      .ent_q(ent_q), .xb_q(xb_q), .fin(fin), .done(done), .err(err)
   );

   nand_probe_lut #(.N(ENT_N)) u_lut (
      .mfr(mfr_q), .dev(dev_q), .hit(lut_hit), .ent(lut_ent)
   );

   nand_probe_geom #(.BLK_W(BLK_W)) u_geom (
      .ent(ent_q), .xb(xb_q), .pg_lg(g_pg), .er_lg(g_er), .ac(g_ac), .blk(g_blk)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pg_lg       <= '0;
         er_lg       <= '0;
         bus_wide    <= 1'b0;
         addr_cycles <= '0;
         blk_count   <= '0;
      end else if (fin) begin
         pg_lg       <= g_pg;
         er_lg       <= g_er;
         bus_wide    <= ent_q.wide;
         addr_cycles <= g_ac;
         blk_count   <= g_blk;
      end
   end

   assert_cycles_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (addr_cycles >= 3'd3 && addr_cycles <= 3'd6));

   assert_blk_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($countones(blk_count) == 1));

   assert_no_tiny_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (pg_lg != PG_LG_TINY));

   assert_geom_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fin) |=> $stable(blk_count));

endmodule

// File: tb/sim_nand_id_probe.sv
module sim_nand_id_probe;

   localparam int CLK_PER = 10;
   localparam int DW      = 16;
   localparam int BW      = 24;

   typedef struct packed {
      logic [7:0] m;
      logic [7:0] d;
      logic [7:0] x;
      logic       e_err;
      logic [3:0] e_pg;
      logic [4:0] e_er;
      logic       e_w;
      logic [2:0] e_ac;
      logic [4:0] e_blk;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{8'hEC, 8'hD7, 8'h00, 1'b0, 4'd13, 5'd20, 1'b0, 3'd5, 5'd12},
      '{8'h98, 8'hD7, 8'h00, 1'b1, 4'd0,  5'd0,  1'b0, 3'd0, 5'd0},
      '{8'h2C, 8'h73, 8'h00, 1'b0, 4'd9,  5'd14, 1'b0, 3'd3, 5'd10},
      '{8'h00, 8'h76, 8'h00, 1'b0, 4'd9,  5'd14, 1'b0, 3'd4, 5'd12},
      '{8'h01, 8'h56, 8'h00, 1'b0, 4'd9,  5'd14, 1'b1, 3'd4, 5'd12},
      '{8'hAD, 8'hF1, 8'h15, 1'b0, 4'd11, 5'd17, 1'b0, 3'd4, 5'd10},
      '{8'h20, 8'hDA, 8'h32, 1'b0, 4'd12, 5'd19, 1'b0, 3'd5, 5'd9},
      '{8'hEC, 8'hC1, 8'hC0, 1'b0, 4'd10, 5'd16, 1'b1, 3'd4, 5'd11},
      '{8'h00, 8'h9B, 8'h00, 1'b0, 4'd9,  5'd14, 1'b0, 3'd5, 5'd20},
      '{8'h00, 8'h9A, 8'h3B, 1'b0, 4'd13, 5'd19, 1'b0, 3'd6, 5'd17},
      '{8'h00, 8'hEC, 8'h00, 1'b1, 4'd0,  5'd0,  1'b0, 3'd0, 5'd0},
      '{8'h00, 8'h11, 8'h00, 1'b1, 4'd0,  5'd0,  1'b0, 3'd0, 5'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          dev_ready = 1'b1;
   logic          rd_valid = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          cmd_stb, cmd_addr, rd_req, bus_wide, done, err;
   logic [7:0]    cmd_byte;
   logic [3:0]    pg_lg;
   logic [4:0]    er_lg;
   logic [2:0]    addr_cycles;
   logic [BW-1:0] blk_count;

   int n_chk = 0;
   int n_fail = 0;
   int n_cmd, n_rd, gap_rdy, gap_adr;
   bit seq_bad, finished, cleared_ok;

   always #(CLK_PER/2) clk = ~clk;

   nand_id_probe #(.DATA_W(DW), .BLK_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_ready(dev_ready),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_byte(cmd_byte), .rd_req(rd_req),
      .pg_lg(pg_lg), .er_lg(er_lg), .bus_wide(bus_wide), .addr_cycles(addr_cycles),
      .blk_count(blk_count), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_probe(input logic [7:0] m, input logic [7:0] d, input logic [7:0] x,
                            input int lat, input int busy_at);
      logic [7:0] ids [5];
      int rdy_cnt, wcnt, t_rst, t_id;
      ids = '{m, d, 8'h5A, 8'hC3, x};
      n_cmd = 0; n_rd = 0; seq_bad = 0; finished = 0; cleared_ok = 0;
      rdy_cnt = 0; wcnt = 0; t_rst = 0; t_id = 0; gap_rdy = 0; gap_adr = 0;
      @(negedge clk);
      start = 1'b1;
      for (int cyc = 0; cyc < 300; cyc++) begin
         @(negedge clk);
         start = (cyc == busy_at);
         if (cyc == 0) cleared_ok = !done && !err;
         if (done || err) begin
            finished = 1;
            break;
         end
         if (cmd_stb) begin
            case (n_cmd)
               0: begin if (cmd_byte != 8'hFF || cmd_addr) seq_bad = 1; t_rst = cyc; end
               1: begin if (cmd_byte != 8'h90 || cmd_addr) seq_bad = 1; t_id = cyc; gap_rdy = cyc - t_rst; end
               2: begin if (cmd_byte != 8'h00 || !cmd_addr) seq_bad = 1; gap_adr = cyc - t_id; end
               default: seq_bad = 1;
            endcase
            n_cmd++;
         end
         if (cmd_stb && cmd_byte == 8'hFF) begin
            dev_ready = 1'b0;
            rdy_cnt   = 3;
         end else if (rdy_cnt > 0) begin
            rdy_cnt--;
            if (rdy_cnt == 0) dev_ready = 1'b1;
         end
         if (rd_req) begin
            if (wcnt >= lat) begin
               rd_valid = 1'b1;
               rd_data  = {8'hA5, (n_rd < 5) ? ids[n_rd] : 8'hFF};
               n_rd++;
               wcnt = 0;
            end else begin
               rd_valid = 1'b0;
               wcnt++;
            end
         end else begin
            rd_valid = 1'b0;
            wcnt = 0;
         end
      end
      start = 1'b0;
      rd_valid = 1'b0;
   endtask

   task automatic judge(input vec_t v, input string nm);
      int exp_rd;
      exp_rd = v.e_err ? 2 : ((v.x != 8'h00 || v.e_pg >= 4'd10) && v.d != 8'hD7 ? 5 : 2);
      chk(finished, {nm, " R10 probe ends"}, finished, 1);
      chk(cleared_ok, {nm, " R10 flags cleared by start"}, cleared_ok, 1);
      chk(!seq_bad && n_cmd == 3, {nm, " R1 strobe order"}, n_cmd, 3);
      chk(gap_rdy == 4, {nm, " R1 ready wait"}, gap_rdy, 4);
      chk(gap_adr == 1, {nm, " R1 address follows"}, gap_adr, 1);
      chk(n_rd == exp_rd, {nm, " R2 R6 read count"}, n_rd, exp_rd);
      chk(err == v.e_err, {nm, " R3 R4 R5 err"}, err, v.e_err);
      chk(done == !v.e_err, {nm, " R4 done"}, done, !v.e_err);
      if (!v.e_err) begin
         chk(pg_lg == v.e_pg, {nm, " R6 page"}, pg_lg, v.e_pg);
         chk(er_lg == v.e_er, {nm, " R6 erase"}, er_lg, v.e_er);
         chk(bus_wide == v.e_w, {nm, " R11 width"}, bus_wide, v.e_w);
         chk(addr_cycles == v.e_ac, {nm, " R7 cycles"}, addr_cycles, v.e_ac);
         chk(blk_count == (BW'(1) << v.e_blk), {nm, " R8 blocks"}, blk_count, BW'(1) << v.e_blk);
      end
   endtask

   initial begin
      #(CLK_PER * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!done && !err && !cmd_stb && !rd_req, "R9 flags after reset", {done, err, cmd_stb, rd_req}, 0);
      chk(pg_lg == 0 && er_lg == 0 && addr_cycles == 0 && blk_count == 0 && !bus_wide,
          "R9 geometry after reset", blk_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cmd_stb && !rd_req && !done, "R9 idle without start", {cmd_stb, rd_req, done}, 0);

      for (int i = 0; i < NV; i++) begin
         run_probe(VEC[i].m, VEC[i].d, VEC[i].x, i % 3, -1);
         judge(VEC[i], $sformatf("vec%0d", i));
      end

      // R10: start pulses during a probe at several offsets
      for (int off = 1; off < 14; off += 3) begin
         run_probe(VEC[5].m, VEC[5].d, VEC[5].x, 1, off);
         judge(VEC[5], $sformatf("busy%0d R10", off));
      end
      run_probe(VEC[2].m, VEC[2].d, VEC[2].x, 0, 2);
      judge(VEC[2], "busy_wait R10");

      // R10: error then success clears err; success then error clears done
      run_probe(VEC[11].m, VEC[11].d, VEC[11].x, 0, -1);
      judge(VEC[11], "err_first R10");
      run_probe(VEC[3].m, VEC[3].d, VEC[3].x, 2, -1);
      judge(VEC[3], "ok_after_err R10");

      // R6: only bits [5:4] and [1:0] of the fifth byte matter
      run_probe(8'h00, 8'hF1, 8'hCA, 0, -1);
      chk(pg_lg == 4'd12 && er_lg == 5'd16, "R6 masked ext bits", {pg_lg, er_lg}, {4'd12, 5'd16});

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule